// File: doc/BRIEF.md
# Shared-Bus Accumulator Register File

This block holds the working registers of a small accumulator machine and the single 16-bit bus that moves words between them. Eight registers sit around the bus: a 12-bit program counter, a 12-bit address register, 16-bit instruction, accumulator, data and temporary registers, and 8-bit input and output registers. An external word-addressed memory is attached. The address register always supplies the memory address. Memory read data is one of the bus sources, and the bus value is the memory write data.

A controller outside this block issues one bus-source code per cycle, along with per-register load, increment and clear strobes. Increment and clear act inside each register, so they can run in the same cycle as a bus transfer. The accumulator is never written from the bus. It takes only the result of a small ALU whose operands are fixed: the accumulator, the data register, the input register and a one-bit carry/link flag E. The input register is filled only from the input device. The output register only feeds the output device.

Top module: `acc_bus_datapath`

## Requirements
- R1: While rst_n is low, and at the first falling clock edge after it rises, every register and E read zero.
- R2: bus_sel chooses the bus value. 0 gives zero, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, and 7 mem_rdata. A 12-bit source fills bus bits 15..12 with zeros.
- R3: reg_ld bits index the registers as 0 address, 1 program counter, 2 data, 3 temporary, 4 instruction and 5 output. A load takes the bus value at the clock edge. The 12-bit registers take bus bits 11..0, and the output register takes bits 7..0.
- R4: Within each register, clear beats load and load beats increment. An increment wraps to zero at the register's width.
- R5: mem_addr always equals the address register. mem_wdata equals the bus, and mem_we follows mem_wr in the same cycle.
- R6: With ac_ld high, alu_op 0 loads AC AND DR. alu_op 1 loads the low 16 bits of AC+DR and puts the carry out into E.
- R7: alu_op 2 copies DR into AC. alu_op 3 replaces AC bits 7..0 with the input register and keeps bits 15..8. alu_op 4 inverts AC. alu_op 7 leaves AC unchanged.
- R8: alu_op 5 rotates {E,AC} one place right, so AC bit 0 goes to E and E goes to AC bit 15. alu_op 6 rotates left, so AC bit 15 goes to E and E goes to AC bit 0.
- R9: The input register loads in_data when in_ld is high and otherwise holds. No bus code selects the input or the output register.
- R10: E changes only on an accumulator ALU load with alu_op 1, 5 or 6. ac_clr beats ac_ld, and ac_ld beats ac_inc. The accumulator changes only through these three controls.
- R11: Increments and clears of registers that are not loaded act in the same cycle as a bus transfer. A memory read into the data register takes two cycles, and so does a write of the data register to the location held in the temporary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 6 | Per-register load strobes (address, program counter, data, temporary, instruction, output) |
| reg_inc | input | 6 | Per-register increment strobes, same indexing |
| reg_clr | input | 6 | Per-register clear strobes, same indexing |
| ac_ld | input | 1 | Load the accumulator from the ALU |
| ac_inc | input | 1 | Increment the accumulator |
| ac_clr | input | 1 | Clear the accumulator |
| alu_op | input | 3 | ALU operation code |
| in_data | input | 8 | Input device data |
| in_ld | input | 1 | Capture in_data into the input register |
| mem_wr | input | 1 | Write request for memory |
| mem_rdata | input | 16 | Memory read data at mem_addr |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| tr_q | output | 16 | Temporary register |
| ir_q | output | 16 | Instruction register |
| ac_q | output | 16 | Accumulator |
| outr_q | output | 8 | Output register, to the output device |
| inpr_q | output | 8 | Input register |
| e_q | output | 1 | Carry/link flag |

## Verification
Directed sequences come first. All-ones memory data loaded into the program counter exposes truncation to 12 bits and the wrap on increment. Clear, load and increment strobes raised together separate the three priority orders. The two-cycle memory read and write transfers show whether the address register really drives memory, and whether the written word comes from the bus. An ALU walk with a carry-producing add followed by both rotates tells apart correct and swapped E routing. After that come two thousand cycles of random source codes and random strobe mixes, checked every cycle against a behavioural model. These catch crossed bus codes and strobe index mix-ups that the directed cases leave out.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int DP_AW  = 12;
  localparam int DP_DW  = 16;
  localparam int DP_IOW = 8;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_XDR  = 3'd2,
    OP_XIN  = 3'd3,
    OP_CMA  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROL  = 3'd6,
    OP_HOLD = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [DP_DW-1:0] res;
    logic             e_new;
    logic             e_upd;
  } alu_out_t;

  // Index map shared by the per-register strobe vectors.
  localparam int IX_AR = 0;
  localparam int IX_PC = 1;
  localparam int IX_DR = 2;
  localparam int IX_TR = 3;
  localparam int IX_IR = 4;
  localparam int IX_OR = 5;
  localparam int NREG  = 6;

  function automatic int bus_reg_width(input int idx);
    return (idx == IX_AR || idx == IX_PC) ? DP_AW : DP_DW;
  endfunction

  function automatic alu_out_t alu_eval(input logic [2:0] op,
                                        input logic [DP_DW-1:0] a,
                                        input logic [DP_DW-1:0] b,
                                        input logic [DP_IOW-1:0] inw,
                                        input logic e);
    alu_out_t o;
    logic [DP_DW:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    o.res   = a;
    o.e_new = e;
    o.e_upd = 1'b0;
    case (alu_op_e'(op))
      OP_AND:  o.res = a & b;
      OP_ADD:  begin o.res = sum[DP_DW-1:0]; o.e_new = sum[DP_DW]; o.e_upd = 1'b1; end
      OP_XDR:  o.res = b;
      OP_XIN:  o.res = {a[DP_DW-1:DP_IOW], inw};
      OP_CMA:  o.res = ~a;
      OP_ROR:  begin o.res = {e, a[DP_DW-1:1]}; o.e_new = a[0]; o.e_upd = 1'b1; end
      OP_ROL:  begin o.res = {a[DP_DW-2:0], e}; o.e_new = a[DP_DW-1]; o.e_upd = 1'b1; end
      default: o.res = a;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/dp_bus_mux.sv
module dp_bus_mux
  import acc_dp_pkg::*;
#(
  parameter int DW = DP_DW
) (
  input  logic [2:0]    sel,
  input  logic [DW-1:0] ar_x,
  input  logic [DW-1:0] pc_x,
  input  logic [DW-1:0] dr_x,
  input  logic [DW-1:0] ac_x,
  input  logic [DW-1:0] ir_x,
  input  logic [DW-1:0] tr_x,
  input  logic [DW-1:0] mem_x,
  output logic [DW-1:0] bus
);
  always_comb begin
    case (bus_src_e'(sel))
      SRC_AR:  bus = ar_x;
      SRC_PC:  bus = pc_x;
      SRC_DR:  bus = dr_x;
      SRC_AC:  bus = ac_x;
      SRC_IR:  bus = ir_x;
      SRC_TR:  bus = tr_x;
      SRC_MEM: bus = mem_x;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import acc_dp_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [DP_DW-1:0]  ac,
  input  logic [DP_DW-1:0]  dr,
  input  logic [DP_IOW-1:0] inpr,
  input  logic              e,
  output logic [DP_DW-1:0]  res,
  output logic              e_new,
  output logic              e_upd
);
  alu_out_t o;
  always_comb begin
    o     = alu_eval(op, ac, dr, inpr, e);
    res   = o.res;
    e_new = o.e_new;
    e_upd = o.e_upd;
  end
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import acc_dp_pkg::*;
#(
  parameter int AW  = DP_AW,
  parameter int DW  = DP_DW,
  parameter int IOW = DP_IOW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      bus_sel,
  input  logic [5:0]      reg_ld,
  input  logic [5:0]      reg_inc,
  input  logic [5:0]      reg_clr,
  input  logic            ac_ld,
  input  logic            ac_inc,
  input  logic            ac_clr,
  input  logic [2:0]      alu_op,
  input  logic [IOW-1:0]  in_data,
  input  logic            in_ld,
  input  logic            mem_wr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic [DW-1:0]   bus_q,
  output logic [AW-1:0]   ar_q,
  output logic [AW-1:0]   pc_q,
  output logic [DW-1:0]   dr_q,
  output logic [DW-1:0]   tr_q,
  output logic [DW-1:0]   ir_q,
  output logic [DW-1:0]   ac_q,
  output logic [IOW-1:0]  outr_q,
  output logic [IOW-1:0]  inpr_q,
  output logic            e_q
);
  localparam int NBUSREG = NREG - 1;

  logic [DW-1:0] bus_w;
  logic [DW-1:0] reg_x [NBUSREG];
  logic [DW-1:0] alu_res_w;
  logic          alu_e_new_w;
  logic          alu_e_upd_w;
  logic          ac_take_alu_w;
  logic          e_write_w;
  logic [DW-1:0] ac_r;
  logic          e_r;

  // Bus-connected registers, zero-extended onto the bus width.
  for (genvar gi = 0; gi < NBUSREG; gi++) begin : g_reg
    localparam int W = bus_reg_width(gi);
    logic [W-1:0] q_w;
    dp_reg #(.W(W)) u_reg (
      .clk (clk), .rst_n (rst_n),
      .clr (reg_clr[gi]), .ld (reg_ld[gi]), .inc (reg_inc[gi]),
      .d   (bus_w[W-1:0]), .q (q_w)
    );
    assign reg_x[gi] = DW'(q_w);
  end

  dp_reg #(.W(IOW)) u_outr (
    .clk (clk), .rst_n (rst_n),
    .clr (reg_clr[IX_OR]), .ld (reg_ld[IX_OR]), .inc (reg_inc[IX_OR]),
    .d   (bus_w[IOW-1:0]), .q (outr_q)
  );

  dp_reg #(.W(IOW)) u_inpr (
    .clk (clk), .rst_n (rst_n),
    .clr (1'b0), .ld (in_ld), .inc (1'b0),
    .d   (in_data), .q (inpr_q)
  );

  dp_bus_mux #(.DW(DW)) u_mux (
    .sel  (bus_sel),
    .ar_x (reg_x[IX_AR]), .pc_x (reg_x[IX_PC]), .dr_x (reg_x[IX_DR]),
    .ac_x (ac_r),         .ir_x (reg_x[IX_IR]), .tr_x (reg_x[IX_TR]),
    .mem_x(mem_rdata),    .bus  (bus_w)
  );

  dp_alu u_alu (
    .op (alu_op), .ac (ac_r), .dr (reg_x[IX_DR]), .inpr (inpr_q), .e (e_r),
    .res (alu_res_w), .e_new (alu_e_new_w), .e_upd (alu_e_upd_w)
  );

  assign ac_take_alu_w = ac_ld && !ac_clr;
  assign e_write_w     = ac_take_alu_w && alu_e_upd_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_r <= '0;
      e_r  <= 1'b0;
    end else begin
      if (ac_clr)             ac_r <= '0;
      else if (ac_ld)         ac_r <= alu_res_w;
      else if (ac_inc)        ac_r <= ac_r + 1'b1;
      if (e_write_w)          e_r  <= alu_e_new_w;
    end
  end

  assign mem_addr  = reg_x[IX_AR][AW-1:0];
  assign mem_wdata = bus_w;
  assign mem_we    = mem_wr;
  assign bus_q     = bus_w;
  assign ar_q      = reg_x[IX_AR][AW-1:0];
  assign pc_q      = reg_x[IX_PC][AW-1:0];
  assign dr_q      = reg_x[IX_DR];
  assign tr_q      = reg_x[IX_TR];
  assign ir_q      = reg_x[IX_IR];
  assign ac_q      = ac_r;
  assign e_q       = e_r;
endmodule

// File: rtl/acc_bus_datapath_chk.sv
module acc_bus_datapath_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_sel,
  input logic [DW-1:0] bus_w,
  input logic [5:0]    reg_ld,
  input logic [5:0]    reg_inc,
  input logic [5:0]    reg_clr,
  input logic          ac_ld,
  input logic          ac_inc,
  input logic          ac_clr,
  input logic [2:0]    alu_op,
  input logic          in_ld,
  input logic [7:0]    inpr_q,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] ac_q,
  input logic          e_q
);
  assert_bus_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd0 |-> bus_w == '0);

  assert_narrow_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_w[DW-1:AW] == '0);

  assert_pc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld[1] && !reg_clr[1]) |=> pc_q == $past(bus_w[AW-1:0]));

  assert_pc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr[1] |=> pc_q == '0);

  assert_pc_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_inc[1] && !reg_ld[1] && !reg_clr[1]) |=> pc_q == AW'($past(pc_q) + 1'b1));

  assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld[0] && !reg_clr[0]) |=> mem_addr == $past(bus_w[AW-1:0]));

  assert_inpr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ld |=> $stable(inpr_q));

  assert_e_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ac_ld && !ac_clr && (alu_op == 3'd1 || alu_op == 3'd5 || alu_op == 3'd6))
      |=> $stable(e_q));

  assert_ac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ac_ld && !ac_inc && !ac_clr) |=> $stable(ac_q));
endmodule

bind acc_bus_datapath acc_bus_datapath_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_acc_bus_datapath.sv
`timescale 1ns/1ps
module sim_acc_bus_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_sel = '0;
  logic [5:0] reg_ld = '0, reg_inc = '0, reg_clr = '0;
  logic ac_ld = 0, ac_inc = 0, ac_clr = 0;
  logic [2:0] alu_op = '0;
  logic [7:0] in_data = '0;
  logic in_ld = 0, mem_wr = 0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr, ar_q, pc_q;
  logic [15:0] mem_wdata, bus_q, dr_q, tr_q, ir_q, ac_q;
  logic mem_we, e_q;
  logic [7:0] outr_q, inpr_q;

  logic [15:0] mem [4096];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_ar, m_pc, m_dr, m_tr, m_ir, m_ac, m_or, m_in, m_e;

  always #2 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  acc_bus_datapath u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_bus(input int s);
    case (s)
      1: return m_ar;  2: return m_pc;  3: return m_dr;  4: return m_ac;
      5: return m_ir;  6: return m_tr;  7: return int'(mem[m_ar]);
      default: return 0;
    endcase
  endfunction

  function automatic int nxt(input int q, input int mask, input bit c, input bit l,
                             input bit i, input int d);
    if (c) return 0;
    if (l) return d % (mask + 1);
    if (i) return (q + 1) % (mask + 1);
    return q;
  endfunction

  task automatic check_regs(input string tag);
    string t;
    t = tag;
    chk(t == "" ? "R3" : t, "ar", int'(ar_q), m_ar);
    chk(t == "" ? "R3" : t, "pc", int'(pc_q), m_pc);
    chk(t == "" ? "R3" : t, "dr", int'(dr_q), m_dr);
    chk(t == "" ? "R3" : t, "tr", int'(tr_q), m_tr);
    chk(t == "" ? "R3" : t, "ir", int'(ir_q), m_ir);
    chk(t == "" ? "R6" : t, "ac", int'(ac_q), m_ac);
    chk(t == "" ? "R10" : t, "e", int'(e_q), m_e);
    chk(t == "" ? "R9" : t, "outr", int'(outr_q), m_or);
    chk(t == "" ? "R9" : t, "inpr", int'(inpr_q), m_in);
  endtask

  task automatic step(input int s, input int ld, input int inc, input int clr,
                      input bit al, input bit ai, input bit acl, input int op,
                      input int id, input bit il, input bit w, input string tag);
    int b, a, e, sum;
    bus_sel = 3'(s); reg_ld = 6'(ld); reg_inc = 6'(inc); reg_clr = 6'(clr);
    ac_ld = al; ac_inc = ai; ac_clr = acl; alu_op = 3'(op);
    in_data = 8'(id); in_ld = il; mem_wr = w;
    #1;
    b = model_bus(s);
    chk(tag == "" ? "R2" : tag, "bus", int'(bus_q), b);
    chk("R5", "mem_addr", int'(mem_addr), m_ar);
    chk("R5", "mem_wdata", int'(mem_wdata), b);
    chk("R5", "mem_we", int'(mem_we), int'(w));
    @(posedge clk);
    if (w) mem[m_ar] = 16'(b);
    a = m_ac; e = m_e;
    if (acl) a = 0;
    else if (al) begin
      case (op)
        0: a = m_ac & m_dr;
        1: begin sum = m_ac + m_dr; a = sum % 65536; e = sum / 65536; end
        2: a = m_dr;
        3: a = (m_ac / 256) * 256 + m_in;
        4: a = 65535 - m_ac;
        5: begin a = m_ac / 2 + m_e * 32768; e = m_ac % 2; end
        6: begin a = (m_ac * 2) % 65536 + m_e; e = m_ac / 32768; end
        default: a = m_ac;
      endcase
    end else if (ai) a = (m_ac + 1) % 65536;
    m_ar = nxt(m_ar, 4095, clr[0], ld[0], inc[0], b);
    m_pc = nxt(m_pc, 4095, clr[1], ld[1], inc[1], b);
    m_dr = nxt(m_dr, 65535, clr[2], ld[2], inc[2], b);
    m_tr = nxt(m_tr, 65535, clr[3], ld[3], inc[3], b);
    m_ir = nxt(m_ir, 65535, clr[4], ld[4], inc[4], b);
    m_or = nxt(m_or, 255, clr[5], ld[5], inc[5], b);
    if (il) m_in = id;
    m_ac = a; m_e = e;
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 37) ^ 16'h5a5a;
    mem[0] = 16'hFFFF;
    mem[12'h123] = 16'hBEEF;
    m_ar = 0; m_pc = 0; m_dr = 0; m_tr = 0; m_ir = 0; m_ac = 0; m_or = 0; m_in = 0; m_e = 0;
    repeat (3) @(negedge clk);
    check_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    // R3/R4: all-ones into PC truncates, then wraps; priority combos
    step(7, 6'b000010, 0, 0, 0,0,0, 0, 0,0,0, "R3");
    step(0, 0, 6'b000010, 0, 0,0,0, 0, 0,0,0, "R4");
    step(7, 6'b000010, 6'b000010, 6'b000010, 0,0,0, 0, 0,0,0, "R4");
    step(7, 6'b000010, 6'b000010, 0, 0,0,0, 0, 0,0,0, "R4");
    step(0, 0, 6'b000010, 0, 0,0,0, 0, 0,0,0, "R4");
    // R11: read M[IR(11..0)] into DR, with PC incrementing alongside
    mem[0] = 16'h7123;
    step(7, 6'b010000, 6'b000010, 0, 0,0,0, 0, 0,0,0, "R11");
    step(5, 6'b000001, 6'b000010, 0, 0,0,0, 0, 0,0,0, "R11");
    step(7, 6'b000100, 0, 6'b001000, 0,0,0, 0, 0,0,0, "R11");
    // R11: write DR to M[TR]
    step(7, 6'b001000, 0, 0, 0,0,0, 0, 0,0,0, "R11");
    step(6, 6'b000001, 0, 0, 0,0,0, 0, 0,0,0, "R11");
    step(3, 0, 0, 0, 0,0,0, 0, 0,0,1, "R5");
    step(7, 6'b000100, 0, 0, 0,0,0, 0, 0,0,0, "R5");
    // ALU walk
    step(0, 0, 0, 0, 1,0,0, 2, 0,0,0, "R7");
    step(0, 0, 0, 0, 1,0,0, 1, 0,0,0, "R6");
    step(0, 0, 0, 0, 1,0,0, 6, 0,0,0, "R8");
    step(0, 0, 0, 0, 1,0,0, 5, 0,0,0, "R8");
    step(0, 0, 0, 0, 1,0,0, 5, 0,0,0, "R8");
    step(0, 0, 0, 0, 1,0,0, 4, 8'h5A,1,0, "R7");
    step(0, 0, 0, 0, 1,0,0, 3, 0,0,0, "R7");
    step(0, 0, 0, 0, 1,0,0, 0, 0,0,0, "R6");
    step(0, 0, 0, 0, 1,0,0, 7, 0,0,0, "R7");
    step(4, 6'b100000, 0, 0, 1,1,1, 1, 8'hC3,0,0, "R10");
    step(0, 0, 0, 0, 0,1,0, 1, 0,0,0, "R10");
    step(0, 0, 0, 0, 0,0,0, 0, 8'h99,0,0, "R9");
    step(4, 6'b100000, 6'b100000, 0, 0,0,0, 0, 0,0,0, "R9");
    // random traffic against the model
    for (int k = 0; k < 2000; k++) begin
      step(int'($urandom_range(0, 7)),
           int'($urandom_range(0, 63)) & int'($urandom_range(0, 63)),
           int'($urandom_range(0, 63)),
           int'($urandom_range(0, 63)) & int'($urandom_range(0, 63)) & int'($urandom_range(0, 63)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), "");
    end
    summary();
  end
endmodule